// File: doc/BRIEF.md
# Write Leveling Responder (Memory Side)

This block is the device-side logic that a memory controller talks to during write leveling. It watches decoded commands and keeps a copy of the mode register that carries the leveling enable. It switches into leveling mode when that register is written with the enable bit set, and back out when the bit is cleared. While leveling, it changes how the on-die termination input is used and which commands are allowed. It also turns the data bus into a feedback channel: every rising strobe edge samples the clock level, and the result goes back to the controller.

The controller sweeps its strobe delay and reads the feedback bits. When it sees the sampled clock move from 0 to 1, it locks that delay. Inputs are a decoded command (opcode, bank bits, address bits), the termination request, a one-cycle strobe-rising pulse and the clock level seen at the strobe. Outputs are:
- the strobe and data termination enables,
- the feedback bus and its output enable,
- the mode flag and register contents,
- two error flags.

A parameter chooses whether a single designated bit or every bit carries the feedback. Another parameter sets the feedback latency in clock cycles.

Top module: `wrlvl_resp`

## Requirements
- R1: After reset, leveling mode is off, the stored MR1 value is all zero, both error flags are low, the data output enable is low and the data bus is zero.
- R2: An MRS command (opcode 2) whose bank bits equal 1 selects MR1. Outside leveling, such a write loads every address bit into the stored value. If address bit 7 is 1, the mode flag is high after the sampling edge.
- R3: Outside leveling, both the strobe and the data termination enables follow the termination input. In leveling, the strobe enable follows it and the data enable stays low.
- R4: In leveling, these commands are illegal: ACT (3), RD (4), WR (5), PRE (6), REF (7), and MRS to any bank other than 1. An illegal command raises the command-error flag for exactly the one cycle after the edge that samples it, and it leaves the stored register unchanged. NOP (0) and DES (1) raise nothing.
- R5: In leveling, an MR1 write with bit 7 set updates only bit 12, the output-off bit. All other stored bits are kept, and no error is raised.
- R6: In leveling, an MR1 write with bit 7 clear leaves leveling mode. It updates only bits 12, 9, 6, 5, 2 and 1, and every other stored bit keeps its value.
- R7: In leveling, a strobe pulse captures the clock level. The captured value appears on the feedback bit after WLO rising edges, counting the edge that samples the pulse. Before that it holds the previous value.
- R8: With single-bit feedback, bit PRIME_IDX carries the value and all other data bits stay low.
- R9: In leveling with bit 12 at 0, the data output enable is high. With bit 12 at 1, the enable is low and the bus reads zero even after strobe pulses.
- R10: The termination setting is the field {bit 9, bit 6, bit 2}. The termination-error flag is high exactly when the block is leveling with bit 12 at 0 and this field is not 001, 010 or 011.
- R11: Outside leveling, strobe pulses and non-MR1 commands have no effect: the bus stays zero, its enable stays low and no error is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Decoded command opcode |
| cmd_ba | input | BA_W | Bank bits; select the mode register on MRS |
| cmd_addr | input | ADDR_W | Address bits carrying the register value |
| odt | input | 1 | Termination request |
| dqs_rise | input | 1 | One-cycle pulse marking a rising strobe edge |
| ck_level | input | 1 | Clock level seen at the strobe edge |
| term_dqs_en | output | 1 | Strobe termination enable |
| term_dq_en | output | 1 | Data termination enable |
| dq_out | output | DQ_W | Feedback bus |
| dq_oe | output | 1 | Feedback bus output enable |
| lvl_mode | output | 1 | Leveling mode active |
| mr1_q | output | ADDR_W | Stored MR1 value |
| err_cmd | output | 1 | Illegal command seen in leveling (one-cycle pulse) |
| err_rtt | output | 1 | Termination setting illegal for leveling with outputs on |

## Verification
The bench targets the places where a wrong design would still look plausible:
- **Masked updates.** Leveling and exit writes use an all-ones address. A design that stored the full word would overwrite held bits such as the additive-latency field, and one that applied the wrong mask would drop the output-off bit or the termination bits.
- **Feedback latency.** The feedback is checked one cycle before and exactly at its expected cycle. An off-by-one pipeline would then show the new value too early or too late.
- **Illegal commands.** Each illegal opcode and a write to a foreign register are sent, and the bench watches for a flag that sticks or is missing.
- **Output-off and normal mode.** Strobe pulses are sent with outputs disabled and outside leveling, to expose a bus that drives feedback when it must stay quiet.
- **Termination check.** The termination-legality flag is checked with outputs on and with outputs off.

// File: rtl/wrlvl_pkg.sv
`timescale 1ns/1ps
package wrlvl_pkg;
   typedef enum logic [2:0] {
      CMD_NOP = 3'd0,
      CMD_DES = 3'd1,
      CMD_MRS = 3'd2,
      CMD_ACT = 3'd3,
      CMD_RD  = 3'd4,
      CMD_WR  = 3'd5,
      CMD_PRE = 3'd6,
      CMD_REF = 3'd7
   } cmd_e;

   // termination codes allowed while leveling with outputs driven
   function automatic logic rtt_lvl_ok(input logic [2:0] code);
      return (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
   endfunction
endpackage

// File: rtl/wrlvl_mr1_ctl.sv
`timescale 1ns/1ps
module wrlvl_mr1_ctl
   import wrlvl_pkg::*;
#(
   parameter int ADDR_W   = 14,
   parameter int BA_W     = 3,
   parameter int MR_SEL   = 1,
   parameter int WL_BIT   = 7,
   parameter int QOFF_BIT = 12,
   parameter logic [ADDR_W-1:0] EXIT_UPD = ADDR_W'(14'h1266)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [BA_W-1:0]   cmd_ba,
   input  logic [ADDR_W-1:0] cmd_addr,
   output logic [ADDR_W-1:0] mr1_q,
   output logic              err_cmd
);
   localparam logic [ADDR_W-1:0] QOFF_M = ADDR_W'(1) << QOFF_BIT;
   localparam logic [ADDR_W-1:0] WL_M   = ADDR_W'(1) << WL_BIT;
   localparam logic [ADDR_W-1:0] EXIT_M = (EXIT_UPD | QOFF_M) & ~WL_M;
   localparam logic [ADDR_W-1:0] HOLD_M = ~(EXIT_M | WL_M);

   if (WL_BIT >= ADDR_W || QOFF_BIT >= ADDR_W)
      $error("wrlvl_mr1_ctl: control bit outside address width");
   if (MR_SEL >= (1 << BA_W))
      $error("wrlvl_mr1_ctl: register select exceeds bank width");

   cmd_e              op;
   logic              is_mr1;
   logic              lvl;
   logic              bad;
   logic [ADDR_W-1:0] mr1_r;
   logic [ADDR_W-1:0] mr1_n;
   logic              err_r;

   assign op     = cmd_e'(cmd_op);
   assign is_mr1 = (op == CMD_MRS) && (cmd_ba == BA_W'(MR_SEL));
   assign lvl    = mr1_r[WL_BIT];

   always_comb begin
      mr1_n = mr1_r;
      bad   = 1'b0;
      if (!lvl) begin
         if (is_mr1) mr1_n = cmd_addr;
      end else begin
         unique case (op)
            CMD_NOP, CMD_DES: ;
            CMD_MRS: begin
               if (!is_mr1) begin
                  bad = 1'b1;
               end else if (cmd_addr[WL_BIT]) begin
                  mr1_n = (mr1_r & ~QOFF_M) | (cmd_addr & QOFF_M);
               end else begin
                  mr1_n = (mr1_r & ~(EXIT_M | WL_M)) | (cmd_addr & EXIT_M);
               end
            end
            default: bad = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mr1_r <= '0;
         err_r <= 1'b0;
      end else begin
         mr1_r <= mr1_n;
         err_r <= bad;
      end
   end

   assign mr1_q   = mr1_r;
   assign err_cmd = err_r;

   // R4
   err_only_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_cmd |-> $past(lvl));
   // R6
   exit_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl && is_mr1 && !cmd_addr[WL_BIT]) |=> !lvl);
   // R5
   hold_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lvl) |-> ((mr1_r ^ $past(mr1_r)) & HOLD_M) == '0);
endmodule

// File: rtl/wrlvl_term.sv
`timescale 1ns/1ps
module wrlvl_term
   import wrlvl_pkg::*;
(
   input  logic       lvl,
   input  logic       qoff,
   input  logic       odt,
   input  logic [2:0] rtt_code,
   output logic       term_dqs_en,
   output logic       term_dq_en,
   output logic       err_rtt
);
   always_comb begin
      term_dqs_en = odt;
      term_dq_en  = lvl ? 1'b0 : odt;
      err_rtt     = lvl && !qoff && !rtt_lvl_ok(rtt_code);
   end
endmodule

// File: rtl/wrlvl_fb_pipe.sv
`timescale 1ns/1ps
module wrlvl_fb_pipe #(
   parameter int DQ_W      = 8,
   parameter int WLO       = 2,
   parameter bit PRIME_ALL = 1'b0,
   parameter int PRIME_IDX = 0
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            lvl,
   input  logic            qoff,
   input  logic            dqs_rise,
   input  logic            ck_level,
   output logic [DQ_W-1:0] dq_out,
   output logic            dq_oe
);
   localparam logic [DQ_W-1:0] PRIME_M = PRIME_ALL ? {DQ_W{1'b1}} : (DQ_W'(1) << PRIME_IDX);

   if (WLO < 1 || WLO > 64)
      $error("wrlvl_fb_pipe: WLO must be within 1..64");
   if (PRIME_IDX >= DQ_W)
      $error("wrlvl_fb_pipe: prime bit outside bus");

   logic [WLO-1:0]  v_p;
   logic [WLO-1:0]  d_p;
   logic            fb_q;
   logic [DQ_W-1:0] fb_vec;

   always_comb begin
      v_p[0] = dqs_rise && lvl;
      d_p[0] = ck_level;
   end

   always_ff @(posedge clk) begin
      for (int i = 1; i < WLO; i++) begin
         if (!rst_n) begin
            v_p[i] <= 1'b0;
            d_p[i] <= 1'b0;
         end else begin
            v_p[i] <= v_p[i-1] && lvl;
            d_p[i] <= d_p[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !lvl) fb_q <= 1'b0;
      else if (v_p[WLO-1]) fb_q <= d_p[WLO-1];
   end

   if (PRIME_ALL) begin : g_all
      assign fb_vec = {DQ_W{fb_q}};
   end else begin : g_one
      always_comb begin
         fb_vec            = '0;
         fb_vec[PRIME_IDX] = fb_q;
      end
   end

   assign dq_oe  = lvl && !qoff;
   assign dq_out = dq_oe ? fb_vec : '0;

   // R8
   nonprime_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dq_out & ~PRIME_M) == '0);
   // R7
   fb_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (v_p[WLO-1] && lvl) |=> (fb_q == $past(d_p[WLO-1])));
   // R11
   fb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(lvl) |-> !fb_q);
endmodule

// File: rtl/wrlvl_resp.sv
`timescale 1ns/1ps
module wrlvl_resp #(
   parameter int DQ_W      = 8,
   parameter int ADDR_W    = 14,
   parameter int BA_W      = 3,
   parameter int WLO       = 2,
   parameter bit PRIME_ALL = 1'b0,
   parameter int PRIME_IDX = 0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd_op,
   input  logic [BA_W-1:0]   cmd_ba,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              odt,
   input  logic              dqs_rise,
   input  logic              ck_level,
   output logic              term_dqs_en,
   output logic              term_dq_en,
   output logic [DQ_W-1:0]   dq_out,
   output logic              dq_oe,
   output logic              lvl_mode,
   output logic [ADDR_W-1:0] mr1_q,
   output logic              err_cmd,
   output logic              err_rtt
);
   localparam int WL_BIT   = 7;
   localparam int QOFF_BIT = 12;
   localparam int RTT_HI   = 9;
   localparam int RTT_MID  = 6;
   localparam int RTT_LO   = 2;

   if (ADDR_W < 13)
      $error("wrlvl_resp: address width must cover bit 12");

   logic [ADDR_W-1:0] mr1_w;

   wrlvl_mr1_ctl #(
      .ADDR_W(ADDR_W), .BA_W(BA_W), .MR_SEL(1),
      .WL_BIT(WL_BIT), .QOFF_BIT(QOFF_BIT)
   ) u_mr1 (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ba(cmd_ba),
      .cmd_addr(cmd_addr), .mr1_q(mr1_w), .err_cmd(err_cmd)
   );

   wrlvl_term u_term (
      .lvl(mr1_w[WL_BIT]), .qoff(mr1_w[QOFF_BIT]), .odt(odt),
      .rtt_code({mr1_w[RTT_HI], mr1_w[RTT_MID], mr1_w[RTT_LO]}),
      .term_dqs_en(term_dqs_en), .term_dq_en(term_dq_en), .err_rtt(err_rtt)
   );

   wrlvl_fb_pipe #(
      .DQ_W(DQ_W), .WLO(WLO), .PRIME_ALL(PRIME_ALL), .PRIME_IDX(PRIME_IDX)
   ) u_fb (
      .clk(clk), .rst_n(rst_n), .lvl(mr1_w[WL_BIT]), .qoff(mr1_w[QOFF_BIT]),
      .dqs_rise(dqs_rise), .ck_level(ck_level), .dq_out(dq_out), .dq_oe(dq_oe)
   );

   assign mr1_q    = mr1_w;
   assign lvl_mode = mr1_w[WL_BIT];

   // R3
   dq_term_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode && odt) |-> (term_dqs_en && !term_dq_en));
endmodule

// File: tb/wrlvl_resp_tb.sv
`timescale 1ns/1ps
module wrlvl_resp_tb;
   import wrlvl_pkg::*;
   localparam int DQ_W = 8, ADDR_W = 14, BA_W = 3, WLO = 2;
   localparam logic [ADDR_W-1:0] EXIT_BITS = 14'h1266;
   localparam logic [ADDR_W-1:0] QOFF = 14'h1000, WLE = 14'h0080;

   logic clk = 0, rst_n = 0, odt = 0, dqs_rise = 0, ck_level = 0;
   logic [2:0] cmd_op = 3'd0;
   logic [BA_W-1:0] cmd_ba = '0;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic term_dqs_en, term_dq_en, dq_oe, lvl_mode, err_cmd, err_rtt;
   logic [DQ_W-1:0] dq_out;
   logic [ADDR_W-1:0] mr1_q;
   logic [ADDR_W-1:0] exp_mr1;
   int n_chk = 0, n_err = 0;

   always #2.5 clk = ~clk;

   wrlvl_resp #(.DQ_W(DQ_W), .ADDR_W(ADDR_W), .BA_W(BA_W), .WLO(WLO)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_ba(cmd_ba), .cmd_addr(cmd_addr),
      .odt(odt), .dqs_rise(dqs_rise), .ck_level(ck_level),
      .term_dqs_en(term_dqs_en), .term_dq_en(term_dq_en), .dq_out(dq_out),
      .dq_oe(dq_oe), .lvl_mode(lvl_mode), .mr1_q(mr1_q),
      .err_cmd(err_cmd), .err_rtt(err_rtt));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one command for one cycle; returns just after the sampling edge
   task automatic send(input cmd_e op, input logic [BA_W-1:0] ba, input logic [ADDR_W-1:0] a);
      @(negedge clk);
      cmd_op = op; cmd_ba = ba; cmd_addr = a;
      @(negedge clk);
      cmd_op = CMD_NOP; cmd_ba = '0; cmd_addr = '0;
   endtask

   // strobe pulse; returns after the edge sampling it plus WLO-1 edges
   task automatic strobe(input logic lvl_ck);
      @(negedge clk);
      dqs_rise = 1; ck_level = lvl_ck;
      @(negedge clk);
      dqs_rise = 0; ck_level = 0;
      repeat (WLO - 1) @(negedge clk);
   endtask

   task automatic t_reset;
      rst_n = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 lvl_mode", lvl_mode, 0);
      chk("R1 mr1_q", mr1_q, 0);
      chk("R1 err_cmd", err_cmd, 0);
      chk("R1 err_rtt", err_rtt, 0);
      chk("R1 dq_oe", dq_oe, 0);
      chk("R1 dq_out", dq_out, 0);
      exp_mr1 = '0;
   endtask

   task automatic t_normal;
      odt = 1; #1;
      chk("R3 normal dqs term", term_dqs_en, 1);
      chk("R3 normal dq term", term_dq_en, 1);
      odt = 0; #1;
      chk("R3 normal term off", {term_dqs_en, term_dq_en}, 0);
      send(CMD_ACT, 0, 14'h0080);
      chk("R11 no err in normal", err_cmd, 0);
      chk("R11 mr1 untouched", mr1_q, exp_mr1);
      strobe(1);
      chk("R11 dq idle", dq_out, 0);
      chk("R11 oe idle", dq_oe, 0);
   endtask

   task automatic t_enter(input logic [ADDR_W-1:0] a);
      send(CMD_MRS, 1, a | WLE);
      exp_mr1 = a | WLE;
      chk("R2 mr1 load", mr1_q, exp_mr1);
      chk("R2 lvl_mode", lvl_mode, 1);
   endtask

   task automatic t_feedback;
      chk("R9 oe on", dq_oe, 1);
      odt = 1; #1;
      chk("R3 lvl dqs term", term_dqs_en, 1);
      chk("R3 lvl dq term", term_dq_en, 0);
      odt = 0;
      chk("R8 before sample", dq_out, 0);
      @(negedge clk);
      dqs_rise = 1; ck_level = 1;
      @(negedge clk);
      dqs_rise = 0; ck_level = 0;
      chk("R7 not yet", dq_out, 0);
      @(negedge clk);
      chk("R7 R8 sample one", dq_out, 8'h01);
      strobe(0);
      chk("R7 sample zero", dq_out, 8'h00);
      strobe(1);
      chk("R7 sample one again", dq_out, 8'h01);
   endtask

   task automatic t_illegal;
      for (int k = 3; k < 8; k++) begin
         send(cmd_e'(k), 0, 14'h3F7F);
         chk("R4 err pulse", err_cmd, 1);
         @(negedge clk);
         chk("R4 err drops", err_cmd, 0);
         chk("R4 mr1 kept", mr1_q, exp_mr1);
      end
      send(CMD_MRS, 2, 14'h0000);
      chk("R4 foreign mrs err", err_cmd, 1);
      chk("R4 still leveling", lvl_mode, 1);
      send(CMD_NOP, 0, 0);
      chk("R4 nop ok", err_cmd, 0);
      send(CMD_DES, 0, 0);
      chk("R4 des ok", err_cmd, 0);
   endtask

   task automatic t_qoff;
      send(CMD_MRS, 1, 14'h3FFF);
      exp_mr1 = exp_mr1 | QOFF;
      chk("R5 only qoff", mr1_q, exp_mr1);
      chk("R5 no err", err_cmd, 0);
      chk("R9 oe off", dq_oe, 0);
      strobe(1);
      chk("R9 bus quiet", dq_out, 0);
      send(CMD_MRS, 1, WLE);
      exp_mr1 = exp_mr1 & ~QOFF;
      chk("R5 qoff cleared", mr1_q, exp_mr1);
      chk("R9 oe back", dq_oe, 1);
   endtask

   task automatic t_exit;
      send(CMD_MRS, 1, 14'h3FFF & ~WLE);
      exp_mr1 = ((exp_mr1 & ~EXIT_BITS) | EXIT_BITS) & ~WLE;
      chk("R6 masked exit", mr1_q, exp_mr1);
      chk("R6 left leveling", lvl_mode, 0);
      chk("R6 oe off", dq_oe, 0);
   endtask

   task automatic t_rtt;
      t_enter(14'h0200);
      chk("R10 bad code", err_rtt, 1);
      send(CMD_MRS, 1, WLE | QOFF);
      exp_mr1 = exp_mr1 | QOFF;
      chk("R10 outputs off", err_rtt, 0);
      send(CMD_MRS, 1, 0);
      chk("R10 exit clears", err_rtt, 0);
      t_enter(14'h0044);
      chk("R10 code 011 ok", err_rtt, 0);
      send(CMD_MRS, 1, 0);
      t_enter(14'h0000);
      chk("R10 code 000 bad", err_rtt, 1);
   endtask

   task automatic finish_run;
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
   end

   initial begin
      t_reset();
      t_normal();
      t_enter(14'h0848);
      chk("R10 legal code", err_rtt, 0);
      t_feedback();
      t_illegal();
      t_qoff();
      t_exit();
      t_rtt();
      finish_run();
   end
endmodule